// File: doc/BRIEF.md
# Circuit Connection Setup Controller

This block drives one circuit-switched channel from the source side. The local core hands it a transfer request that names a destination and a word count. The controller then sends a setup header into the network and waits for an acknowledge. The acknowledge means the whole path to the destination is reserved. Only after that does the controller pass the core's payload words into the network. These words carry a type code and data, and nothing that routes them. When the last word has gone, the controller sends one teardown word that frees the path, and it becomes ready again.

The total time of a connection falls into two parts. The setup part covers the header trip and the acknowledge. The transfer part covers the payload and the teardown. Each payload word costs no extra cycle: it passes straight from the core to the network, with the network's ready fed back to the core. If no acknowledge comes back within a programmable number of cycles, the request is dropped. The controller then pulses an error flag and returns to idle.

Top module: `cs_conn_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1 and net_valid_o, pay_ready_o and err_o are 0. req_ready_o is 1 only while no connection is in progress. A request is taken on a cycle where both req_valid_i and req_ready_o are 1.
- R2: The first word after a request is taken is the header. Bits [DATA_W+1:DATA_W] hold 2'b01, bits [DEST_W-1:0] hold the destination, and all other bits are 0. The header stays valid and unchanged until net_ready_i accepts it.
- R3: After the header is accepted, net_valid_o stays 0 until an acknowledge is seen, so no payload word can enter the network before the path is reserved.
- R4: In the payload phase each word carries 2'b10 in bits [DATA_W+1:DATA_W] and pay_data_i in bits [DATA_W-1:0]. In this phase net_valid_o equals pay_valid_i and pay_ready_o equals net_ready_i. pay_ready_o is 0 in every other phase.
- R5: Exactly the requested number of payload words are sent. Then one teardown word follows: 2'b11 in the top two bits and 0 elsewhere. It is held until accepted, and the controller is ready again in the next cycle.
- R6: Let T be the value of ack_to_i, with 0 treated as 1. An acknowledge in any of the first T cycles after the header is accepted is taken. If none arrives, the controller is back in idle in the next cycle, with err_o high for exactly that one cycle.
- R7: ack_i has no effect while the controller is in idle, sending the header, sending payload or tearing down.
- R8: A request with a word count of 0 goes from the acknowledge straight to the teardown word, with no payload word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request from the core |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_dest_i | input | DEST_W | Destination of the request |
| req_len_i | input | LEN_W | Number of payload words |
| pay_valid_i | input | 1 | Payload word valid from the core |
| pay_data_i | input | DATA_W | Payload word from the core |
| pay_ready_o | output | 1 | Payload word taken by the network |
| net_valid_o | output | 1 | Word toward the network valid |
| net_ready_i | input | 1 | Network accepts the word |
| net_word_o | output | DATA_W+2 | Type code and contents of the outgoing word |
| ack_i | input | 1 | Path-reserved acknowledge from the network |
| ack_to_i | input | TO_W | Acknowledge timeout in cycles |
| err_o | output | 1 | One-cycle pulse when the acknowledge times out |

## Verification
Random transfers vary the destination, the word count, the acknowledge delay, network backpressure and gaps in the core's payload. Comparing each accepted word with the expected sequence separates a wrong type code or a misplaced field from a dropped or repeated word. Directed runs place the acknowledge on the last allowed cycle and one cycle past it, which pins the timeout boundary to the exact cycle. They also use a timeout of 0 and a word count of 0. Stray acknowledges sent in idle and during the header, payload and teardown phases show whether the controller reacts to ack_i outside the waiting window.

// File: rtl/cs_conn_pkg.sv
package cs_conn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_WAIT_ACK, ST_DATA, ST_TEARDOWN
  } cs_state_e;

  typedef enum logic [1:0] {
    WT_NONE = 2'b00,
    WT_HDR  = 2'b01,
    WT_DATA = 2'b10,
    WT_TEAR = 2'b11
  } cs_wtype_e;
endpackage

// File: rtl/cs_ack_timer.sv
module cs_ack_timer #(
  parameter int TO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expire_o
);
  logic [TO_W-1:0] cnt_q;
  logic [TO_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  // limit 0 behaves like 1
  assign expire_o = run_i && (cnt_inc >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i)             cnt_q <= '0;
    else if (!expire_o)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cs_beat_cnt.sv
module cs_beat_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dec_i,
  output logic             zero_o,
  output logic             last_o
);
  logic [LEN_W-1:0] rem_q;

  assign zero_o = (rem_q == '0);
  assign last_o = (rem_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rem_q <= '0;
    else if (load_i)             rem_q <= len_i;
    else if (dec_i && !zero_o)   rem_q <= rem_q - 1'b1;
  end
endmodule

// File: rtl/cs_word_fmt.sv
module cs_word_fmt
  import cs_conn_pkg::*;
#(
  parameter int DEST_W = 4,
  parameter int DATA_W = 16
) (
  input  cs_wtype_e         sel_i,
  input  logic [DEST_W-1:0] dest_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W+1:0] word_o
);
  localparam int PAD_W = DATA_W - DEST_W;

  logic [DATA_W-1:0] hdr_body;

  generate
    if (PAD_W > 0) begin : g_pad
      assign hdr_body = {{PAD_W{1'b0}}, dest_i};
    end else begin : g_nopad
      assign hdr_body = dest_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      WT_HDR:  word_o = {WT_HDR, hdr_body};
      WT_DATA: word_o = {WT_DATA, data_i};
      WT_TEAR: word_o = {WT_TEAR, {DATA_W{1'b0}}};
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/cs_conn_ctrl.sv
module cs_conn_ctrl
  import cs_conn_pkg::*;
#(
  parameter int DEST_W = 4,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int TO_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DEST_W-1:0] req_dest_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              pay_valid_i,
  input  logic [DATA_W-1:0] pay_data_i,
  output logic              pay_ready_o,
  output logic              net_valid_o,
  input  logic              net_ready_i,
  output logic [DATA_W+1:0] net_word_o,
  input  logic              ack_i,
  input  logic [TO_W-1:0]   ack_to_i,
  output logic              err_o
);
  cs_state_e         state_q, state_d;
  logic [DEST_W-1:0] dest_q;
  logic              err_q;
  logic              accept, beat, expire, len_zero, len_last;
  cs_wtype_e         sel;

  assign accept = (state_q == ST_IDLE) && req_valid_i;
  assign beat   = (state_q == ST_DATA) && pay_valid_i && net_ready_i;

  cs_ack_timer #(.TO_W(TO_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_WAIT_ACK),
    .limit_i  (ack_to_i),
    .expire_o (expire)
  );

  cs_beat_cnt #(.LEN_W(LEN_W)) u_beats (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .len_i  (req_len_i),
    .dec_i  (beat),
    .zero_o (len_zero),
    .last_o (len_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid_i) state_d = ST_SETUP;
      ST_SETUP:    if (net_ready_i) state_d = ST_WAIT_ACK;
      ST_WAIT_ACK: begin
        if (ack_i)       state_d = len_zero ? ST_TEARDOWN : ST_DATA;
        else if (expire) state_d = ST_IDLE;
      end
      ST_DATA:     if (beat && len_last) state_d = ST_TEARDOWN;
      ST_TEARDOWN: if (net_ready_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dest_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= (state_q == ST_WAIT_ACK) && !ack_i && expire;
      if (accept) dest_q <= req_dest_i;
    end
  end

  always_comb begin
    sel         = WT_NONE;
    net_valid_o = 1'b0;
    unique case (state_q)
      ST_SETUP:    begin sel = WT_HDR;  net_valid_o = 1'b1;        end
      ST_DATA:     begin sel = WT_DATA; net_valid_o = pay_valid_i; end
      ST_TEARDOWN: begin sel = WT_TEAR; net_valid_o = 1'b1;        end
      default:     ;
    endcase
  end

  cs_word_fmt #(.DEST_W(DEST_W), .DATA_W(DATA_W)) u_fmt (
    .sel_i  (sel),
    .dest_i (dest_q),
    .data_i (pay_data_i),
    .word_o (net_word_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign pay_ready_o = (state_q == ST_DATA) && net_ready_i;
  assign err_o       = err_q;
endmodule

// File: rtl/cs_conn_chk.sv
module cs_conn_chk #(
  parameter int DEST_W = 4,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [DEST_W-1:0] req_dest_i,
  input logic [LEN_W-1:0]  req_len_i,
  input logic              pay_valid_i,
  input logic [DATA_W-1:0] pay_data_i,
  input logic              pay_ready_o,
  input logic              net_valid_o,
  input logic              net_ready_i,
  input logic [DATA_W+1:0] net_word_o,
  input logic              ack_i,
  input logic              err_o
);
  logic [1:0]        wtype;
  logic              hdr_hs, tear_hs, data_hs;
  logic              armed_q, conn_q;
  logic [LEN_W-1:0]  beats_q, len_q;
  logic [DEST_W-1:0] dest_q;

  assign wtype   = net_word_o[DATA_W+1:DATA_W];
  assign hdr_hs  = net_valid_o && net_ready_i && (wtype == 2'b01);
  assign tear_hs = net_valid_o && net_ready_i && (wtype == 2'b11);
  assign data_hs = net_valid_o && net_ready_i && (wtype == 2'b10);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      conn_q  <= 1'b0;
      beats_q <= '0;
      len_q   <= '0;
      dest_q  <= '0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        len_q  <= req_len_i;
        dest_q <= req_dest_i;
      end
      if (hdr_hs) armed_q <= 1'b1;
      else if (req_ready_o || (armed_q && ack_i)) armed_q <= 1'b0;
      if (armed_q && ack_i && !req_ready_o) conn_q <= 1'b1;
      else if (tear_hs) conn_q <= 1'b0;
      if (hdr_hs) beats_q <= '0;
      else if (data_hs) beats_q <= beats_q + 1'b1;
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!net_valid_o && !pay_ready_o));

  p_hdr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_valid_o && !net_ready_i && wtype != 2'b10) |=> (net_valid_o && $stable(net_word_o)));

  p_hdr_dest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_valid_o && wtype == 2'b01) |-> (net_word_o[DEST_W-1:0] == dest_q));

  p_no_early_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_valid_o && wtype == 2'b10) |-> conn_q);

  p_data_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_valid_o && wtype == 2'b10) |-> (net_word_o[DATA_W-1:0] == pay_data_i));

  p_pay_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_ready_o |-> (net_ready_i && pay_valid_i == net_valid_o));

  p_len_exact_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tear_hs |-> (beats_q == len_q));

  p_err_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_err_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (req_ready_o && !conn_q));
endmodule

bind cs_conn_ctrl cs_conn_chk #(
  .DEST_W(DEST_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_dest_i  (req_dest_i),
  .req_len_i   (req_len_i),
  .pay_valid_i (pay_valid_i),
  .pay_data_i  (pay_data_i),
  .pay_ready_o (pay_ready_o),
  .net_valid_o (net_valid_o),
  .net_ready_i (net_ready_i),
  .net_word_o  (net_word_o),
  .ack_i       (ack_i),
  .err_o       (err_o)
);

// File: tb/sim_cs_conn_ctrl.sv
`timescale 1ns/1ps
module sim_cs_conn_ctrl;
  localparam int DEST_W = 4;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 8;
  localparam int TO_W   = 8;
  localparam int WORD_W = DATA_W + 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [DEST_W-1:0] req_dest_i = '0;
  logic [LEN_W-1:0]  req_len_i = '0;
  logic              pay_valid_i = 1'b0;
  logic [DATA_W-1:0] pay_data_i = '0;
  logic              pay_ready_o;
  logic              net_valid_o;
  logic              net_ready_i = 1'b0;
  logic [WORD_W-1:0] net_word_o;
  logic              ack_i = 1'b0;
  logic [TO_W-1:0]   ack_to_i = 8'd4;
  logic              err_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  cs_conn_ctrl #(.DEST_W(DEST_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .TO_W(TO_W)) u0 (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_dest_i, .req_len_i,
    .pay_valid_i, .pay_data_i, .pay_ready_o, .net_valid_o, .net_ready_i,
    .net_word_o, .ack_i, .ack_to_i, .err_o
  );

  function automatic logic [WORD_W-1:0] hdr_word(logic [DEST_W-1:0] d);
    return {2'b01, {(DATA_W-DEST_W){1'b0}}, d};
  endfunction
  function automatic logic [WORD_W-1:0] data_word(logic [DATA_W-1:0] d);
    return {2'b10, d};
  endfunction
  function automatic logic [WORD_W-1:0] tear_word();
    return {2'b11, {DATA_W{1'b0}}};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one connection; ack_dly = wait cycles before ack, >= limit means timeout
  task automatic run_txn(logic [DEST_W-1:0] dest, logic [LEN_W-1:0] len,
                         int ack_dly, int limit, bit stray);
    int sent;
    bit hs;
    int eff;
    eff = (limit == 0) ? 1 : limit;
    ack_to_i = TO_W'(limit);
    check("R1 ready before request", 32'(req_ready_o), 32'd1);
    req_valid_i = 1'b1; req_dest_i = dest; req_len_i = len;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #1 check("R1 ready low while busy", 32'(req_ready_o), 32'd0);
    // header
    hs = 0;
    while (!hs) begin
      net_ready_i = 1'($urandom_range(0, 1));
      ack_i = stray ? 1'($urandom_range(0, 1)) : 1'b0;
      #1;
      check("R2 header valid", 32'(net_valid_o), 32'd1);
      check("R2 header word", 32'(net_word_o), 32'(hdr_word(dest)));
      check("R4 pay_ready low in header", 32'(pay_ready_o), 32'd0);
      hs = net_ready_i;
      @(negedge clk_i);
    end
    ack_i = 1'b0;
    net_ready_i = 1'b1;
    // waiting
    for (int d = 0; d < ack_dly && d < eff; d++) begin
      #1 check("R3 no word while waiting", 32'(net_valid_o), 32'd0);
      @(negedge clk_i);
    end
    if (ack_dly >= eff) begin
      #1;
      check("R6 err pulse on timeout", 32'(err_o), 32'd1);
      check("R6 idle after timeout", 32'(req_ready_o), 32'd1);
      @(negedge clk_i);
      #1 check("R6 err one cycle", 32'(err_o), 32'd0);
      net_ready_i = 1'b0;
      return;
    end
    ack_i = 1'b1;
    #1 check("R3 no word on ack cycle", 32'(net_valid_o), 32'd0);
    check("R6 no err on accepted ack", 32'(err_o), 32'd0);
    @(negedge clk_i);
    ack_i = 1'b0;
    // payload
    sent = 0;
    while (sent < int'(len)) begin
      pay_valid_i = 1'($urandom_range(0, 3) != 0);
      pay_data_i  = DATA_W'($urandom);
      net_ready_i = 1'($urandom_range(0, 3) != 0);
      ack_i = stray ? 1'($urandom_range(0, 1)) : 1'b0;
      #1;
      check("R4 valid follows core", 32'(net_valid_o), 32'(pay_valid_i));
      check("R4 ready follows network", 32'(pay_ready_o), 32'(net_ready_i));
      if (pay_valid_i)
        check("R4 payload word", 32'(net_word_o), 32'(data_word(pay_data_i)));
      if (pay_valid_i && net_ready_i) sent++;
      @(negedge clk_i);
    end
    pay_valid_i = 1'b0;
    // teardown
    hs = 0;
    while (!hs) begin
      net_ready_i = 1'($urandom_range(0, 1));
      ack_i = stray ? 1'($urandom_range(0, 1)) : 1'b0;
      #1;
      if (len == 0) check("R8 teardown right after ack", 32'(net_word_o), 32'(tear_word()));
      else check("R5 teardown word", 32'(net_word_o), 32'(tear_word()));
      check("R5 teardown valid", 32'(net_valid_o), 32'd1);
      hs = net_ready_i;
      @(negedge clk_i);
    end
    ack_i = 1'b0;
    net_ready_i = 1'b0;
    #1 check("R5 ready after teardown", 32'(req_ready_o), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    #1;
    check("R1 reset ready", 32'(req_ready_o), 32'd1);
    check("R1 reset net_valid", 32'(net_valid_o), 32'd0);
    check("R1 reset pay_ready", 32'(pay_ready_o), 32'd0);
    check("R1 reset err", 32'(err_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7: stray ack in idle
    ack_i = 1'b1;
    repeat (3) begin
      #1;
      check("R7 idle ack ignored valid", 32'(net_valid_o), 32'd0);
      check("R7 idle ack ignored ready", 32'(req_ready_o), 32'd1);
      @(negedge clk_i);
    end
    ack_i = 1'b0;
    // directed corners
    run_txn(4'h5, 8'd3, 0, 4, 0);
    run_txn(4'hA, 8'd0, 2, 4, 0);   // R8
    run_txn(4'h3, 8'd2, 3, 4, 0);   // R6 last allowed cycle
    run_txn(4'h7, 8'd2, 4, 4, 0);   // R6 one past
    run_txn(4'h1, 8'd1, 0, 0, 0);   // R6 limit 0 as 1, ack in time
    run_txn(4'h2, 8'd1, 1, 0, 0);   // R6 limit 0 as 1, timeout
    run_txn(4'hF, 8'd12, 1, 6, 1);  // R7 stray acks
    // random mix
    for (int i = 0; i < 60; i++) begin
      int lim, dly;
      lim = $urandom_range(1, 6);
      dly = $urandom_range(0, lim);
      run_txn(DEST_W'($urandom), LEN_W'($urandom_range(0, 6)), dly, lim,
              1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule